// File: doc/BRIEF.md
# Triangle PWM Timer with Guarded Dead-Time Bounds

This block is a symmetric (up/down) PWM time base. A counter climbs one step per clock from a lower turning point to an upper turning point, then descends back, forming a triangle wave. The upper turning point is the period value minus an upper dead-time value. The lower turning point is a lower dead-time value. Two compare channels, one on the peak side and one on the valley side, each raise a one-clock interrupt pulse when the counter passes their value on either slope.

Configuration arrives through a simple write port. With buffered reload enabled, writes land in shadow registers. The peak group (period, upper dead time, peak-side compare) is copied into the working set when the counter turns at the top. The valley group (lower dead time, valley-side compare) is copied when the counter turns at the bottom. This keeps each half-period bounded by one consistent set of values. With reload disabled, period and compare writes take effect at once, and dead-time writes are refused. A dead-time write is also refused unless the write just before it put the unlock key into the key address.

Right after a reload has moved a boundary, a compare channel whose value equals the new boundary is kept quiet for that one following cycle. A synchronous run input starts the wave at the lower bound, counting up, and freezes it when low.

Top module: `tri_pwm_timer`

## Requirements
- R1: After reset the counter reads 0, the direction output reads 1 (up), and irqPeak, irqValley and wrErr are all 0.
- R2: While run is low the counter holds its value. On the first clock edge that samples run high after a low period, the counter loads the current lower bound and countUp becomes 1.
- R3: While running, the counter steps by one each clock. Counting up, the edge that samples the counter at or above (period − upper dead time) turns it down. Counting down, the edge that samples it at or below the lower dead time turns it up.
- R4: irqPeak (irqValley) is high for exactly the one clock after an edge that sampled a running counter equal to the working peak-side (valley-side) compare value, on both slopes.
- R5: With reloadEn = 1, writes to address 0 (period), 1 (upper dead time) and 3 (peak compare) are buffered and copied into the working set on the turning edge at the top. Writes to address 2 (lower dead time) and 4 (valley compare) are copied on the turning edge at the bottom.
- R6: With reloadEn = 0, writes to addresses 0, 3 and 4 reach the working set on the edge that samples the write.
- R7: A write to address 1 or 2 is accepted only if reloadEn = 1 and the previous write was to address 5 with the unlock key. Otherwise it changes nothing, and wrErr is high for the one clock after the edge that sampled it.
- R8: A dead-time write made with reloadEn = 0 is discarded and raises wrErr, even right after a valid key.
- R9: Any write other than the key, including a key write with the wrong value or a write to addresses 6 and 7, relocks the dead-time registers.
- R10: In the clock following a top reload, a peak-side compare value equal to the new upper bound produces no irqPeak pulse.
- R11: In the clock following a bottom reload, a valley-side compare value equal to the new lower bound produces no irqValley pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Counter run enable, synchronous |
| reloadEn | input | 1 | 1: buffered reload at turning points; 0: immediate writes, dead time locked |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 3 | Write address: 0 period, 1 upper dead time, 2 lower dead time, 3 peak compare, 4 valley compare, 5 unlock key |
| wrData | input | CNT_W | Write data |
| cnt | output | CNT_W | Current counter value |
| countUp | output | 1 | Counting direction, 1 = up |
| irqPeak | output | 1 | Peak-side compare match pulse |
| irqValley | output | 1 | Valley-side compare match pulse |
| wrErr | output | 1 | Pulse for a refused dead-time write |

## Verification
The bench builds the timer with a period of 20, an upper dead time of 3 and a lower dead time of 2. These values give a first triangle between 2 and 17 of about thirty clocks. Many peaks and valleys therefore fit in a short run, so each reload, rejected write and suppression window is reached several times. The small bounds also make it easy to move a boundary by exactly one step, which is what it takes to put a compare value on the new boundary in the cycle after a reload.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;

  localparam int ADDR_W   = 3;
  localparam int NUM_REGS = 5;

  // write address map
  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd0;
  localparam logic [ADDR_W-1:0] A_DT_HI  = 3'd1;
  localparam logic [ADDR_W-1:0] A_DT_LO  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP_PK = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMP_VL = 3'd4;
  localparam logic [ADDR_W-1:0] A_KEY    = 3'd5;

  // registers reloaded at the top turning point (bit index = address)
  localparam logic [NUM_REGS-1:0] PEAK_GROUP = 5'b01011;

  typedef struct packed {
    logic              start;
    logic              step;
    logic              ldPeak;
    logic              ldValley;
    logic              wrBuf;
    logic              wrAct;
    logic [ADDR_W-1:0] wrSel;
  } strobes_t;

endpackage

// File: rtl/tpwm_ctrl.sv
module tpwm_ctrl
  import tpwm_pkg::*;
#(
  parameter int              CNT_W      = 16,
  parameter logic [CNT_W-1:0] UNLOCK_KEY = CNT_W'(16'hA5C3)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              run,
  input  logic              reloadEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              atPeak,
  input  logic              atValley,
  output strobes_t          stb,
  output logic              wrErr
);

  logic running;
  logic unlocked;
  logic isDeadTime;
  logic isDataReg;
  logic dtAllowed;
  logic keyHit;

  always_comb begin
    isDeadTime = wrEn && (wrAddr == A_DT_HI || wrAddr == A_DT_LO);
    isDataReg  = wrEn && (wrAddr <= A_CMP_VL);
    dtAllowed  = unlocked && reloadEn;
    keyHit     = wrEn && (wrAddr == A_KEY) && (wrData == UNLOCK_KEY);

    stb.start    = run && !running;
    stb.step     = run && running;
    stb.ldPeak   = run && running && atPeak && reloadEn;
    stb.ldValley = run && running && atValley && reloadEn;
    stb.wrSel    = wrAddr;
    stb.wrBuf    = isDataReg && (!isDeadTime || dtAllowed);
    stb.wrAct    = isDataReg && !isDeadTime && !reloadEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      unlocked <= 1'b0;
      wrErr    <= 1'b0;
    end else begin
      running <= run;
      if (wrEn) unlocked <= keyHit;
      wrErr <= isDeadTime && !dtAllowed;
    end
  end

endmodule

// File: rtl/tpwm_datapath.sv
module tpwm_datapath
  import tpwm_pkg::*;
#(
  parameter int               CNT_W      = 16,
  parameter logic [CNT_W-1:0] RST_PERIOD = CNT_W'(1000),
  parameter logic [CNT_W-1:0] RST_DT_HI  = CNT_W'(16),
  parameter logic [CNT_W-1:0] RST_DT_LO  = CNT_W'(16)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         stb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cnt,
  output logic             countUp,
  output logic             atPeak,
  output logic             atValley,
  output logic             irqPeak,
  output logic             irqValley
);

  logic [CNT_W-1:0] actR [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] SEL = ADDR_W'(i);
    localparam logic [CNT_W-1:0] RV =
      (i == 0) ? RST_PERIOD :
      (i == 1) ? RST_DT_HI  :
      (i == 2) ? RST_DT_LO  : '0;
    localparam bit IN_PEAK = PEAK_GROUP[i];

    logic [CNT_W-1:0] bufQ;
    logic [CNT_W-1:0] actQ;
    logic             loadHere;

    assign loadHere = IN_PEAK ? stb.ldPeak : stb.ldValley;
    assign actR[i]  = actQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bufQ <= RV;
        actQ <= RV;
      end else begin
        if (stb.wrBuf && stb.wrSel == SEL) bufQ <= wrData;
        if (stb.wrAct && stb.wrSel == SEL) actQ <= wrData;
        else if (loadHere)                 actQ <= bufQ;
      end
    end
  end

  logic [CNT_W-1:0] maxV;
  logic [CNT_W-1:0] minV;
  logic [CNT_W-1:0] cmpPk;
  logic [CNT_W-1:0] cmpVl;
  logic             suppPk;
  logic             suppVl;
  logic             hitPk;
  logic             hitVl;

  always_comb begin
    maxV     = actR[0] - actR[1];
    minV     = actR[2];
    cmpPk    = actR[3];
    cmpVl    = actR[4];
    atPeak   = countUp && (cnt >= maxV);
    atValley = !countUp && (cnt <= minV);
    hitPk    = stb.step && (cnt == cmpPk) && !(suppPk && cmpPk == maxV);
    hitVl    = stb.step && (cnt == cmpVl) && !(suppVl && cmpVl == minV);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      countUp <= 1'b1;
    end else if (stb.start) begin
      cnt     <= minV;
      countUp <= 1'b1;
    end else if (stb.step) begin
      if (atPeak) begin
        cnt     <= cnt - 1'b1;
        countUp <= 1'b0;
      end else if (atValley) begin
        cnt     <= cnt + 1'b1;
        countUp <= 1'b1;
      end else if (countUp) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      suppPk    <= 1'b0;
      suppVl    <= 1'b0;
      irqPeak   <= 1'b0;
      irqValley <= 1'b0;
    end else begin
      suppPk    <= stb.ldPeak;
      suppVl    <= stb.ldValley;
      irqPeak   <= hitPk;
      irqValley <= hitVl;
    end
  end

endmodule

// File: rtl/tri_pwm_timer.sv
module tri_pwm_timer
  import tpwm_pkg::*;
#(
  parameter int               CNT_W      = 16,
  parameter logic [CNT_W-1:0] RST_PERIOD = CNT_W'(1000),
  parameter logic [CNT_W-1:0] RST_DT_HI  = CNT_W'(16),
  parameter logic [CNT_W-1:0] RST_DT_LO  = CNT_W'(16),
  parameter logic [CNT_W-1:0] UNLOCK_KEY = CNT_W'(16'hA5C3)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             reloadEn,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cnt,
  output logic             countUp,
  output logic             irqPeak,
  output logic             irqValley,
  output logic             wrErr
);

  strobes_t stb;
  logic     atPeak;
  logic     atValley;

  tpwm_ctrl #(
    .CNT_W      (CNT_W),
    .UNLOCK_KEY (UNLOCK_KEY)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .run      (run),
    .reloadEn (reloadEn),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .atPeak   (atPeak),
    .atValley (atValley),
    .stb      (stb),
    .wrErr    (wrErr)
  );

  tpwm_datapath #(
    .CNT_W      (CNT_W),
    .RST_PERIOD (RST_PERIOD),
    .RST_DT_HI  (RST_DT_HI),
    .RST_DT_LO  (RST_DT_LO)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (wrData),
    .cnt       (cnt),
    .countUp   (countUp),
    .atPeak    (atPeak),
    .atValley  (atValley),
    .irqPeak   (irqPeak),
    .irqValley (irqValley)
  );

endmodule

// File: rtl/tri_pwm_timer_chk.sv
module tri_pwm_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             run,
  input logic             wrEn,
  input logic [2:0]       wrAddr,
  input logic [CNT_W-1:0] cnt,
  input logic             irqPeak,
  input logic             irqValley,
  input logic             wrErr
);

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    !$past(run) |-> $stable(cnt)); // R2

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(run, 2) && $past(run)) |->
      (cnt == CNT_W'($past(cnt) + 1'b1) || cnt == CNT_W'($past(cnt) - 1'b1))); // R3

  AST_PK_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    irqPeak |=> !irqPeak); // R4

  AST_VL_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    irqValley |=> !irqValley); // R4

  AST_IRQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (irqPeak || irqValley) |-> $past(run)); // R4

  AST_ERR_FROM_DT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrErr |-> ($past(wrEn) && ($past(wrAddr) == 3'd1 || $past(wrAddr) == 3'd2))); // R7

endmodule

bind tri_pwm_timer tri_pwm_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .run       (run),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .cnt       (cnt),
  .irqPeak   (irqPeak),
  .irqValley (irqValley),
  .wrErr     (wrErr)
);

// File: tb/tri_pwm_timer_tb_top.sv
module tri_pwm_timer_tb_top;

  localparam int W   = 16;
  localparam int P0  = 20;
  localparam int DH0 = 3;
  localparam int DL0 = 2;
  localparam int KEY = 16'h5A3C;

  logic         clk;
  logic         rstN;
  logic         run;
  logic         reloadEn;
  logic         wrEn;
  logic [2:0]   wrAddr;
  logic [W-1:0] wrData;
  logic [W-1:0] cnt;
  logic         countUp;
  logic         irqPeak;
  logic         irqValley;
  logic         wrErr;

  tri_pwm_timer #(
    .CNT_W      (W),
    .RST_PERIOD (W'(P0)),
    .RST_DT_HI  (W'(DH0)),
    .RST_DT_LO  (W'(DL0)),
    .UNLOCK_KEY (W'(KEY))
  ) dut_i (
    .clk(clk), .rstN(rstN), .run(run), .reloadEn(reloadEn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cnt(cnt), .countUp(countUp), .irqPeak(irqPeak),
    .irqValley(irqValley), .wrErr(wrErr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mCnt, mUp, mRun, mUnl, mErr, mIrqPk, mIrqVl, mSupPk, mSupVl;
  int mBuf[5];
  int mAct[5];
  int mx, mn;
  bit stepNow, startNow, pkEv, vlEv, hitPk, hitVl, isDt, dtOk;
  int supChkPk = 0, supChkVl = 0;
  int nPeaks = 0, nValleys = 0, lastPeak = -1, lastValley = -1;
  int prevCnt = 0, prevUp = 1;

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mUp = 1; mRun = 0; mUnl = 0; mErr = 0;
      mIrqPk = 0; mIrqVl = 0; mSupPk = 0; mSupVl = 0;
      mBuf = '{P0, DH0, DL0, 0, 0};
      mAct = '{P0, DH0, DL0, 0, 0};
      hitPk = 0; hitVl = 0;
    end else begin
      mx = (mAct[0] - mAct[1]) & 16'hFFFF;
      mn = mAct[2];
      stepNow  = run && mRun;
      startNow = run && !mRun;
      pkEv = stepNow && mUp == 1 && mCnt >= mx;
      vlEv = stepNow && mUp == 0 && mCnt <= mn;
      hitPk = stepNow && mCnt == mAct[3] && mSupPk == 1 && mAct[3] == mx;
      hitVl = stepNow && mCnt == mAct[4] && mSupVl == 1 && mAct[4] == mn;
      mIrqPk = (stepNow && mCnt == mAct[3] && !hitPk) ? 1 : 0;
      mIrqVl = (stepNow && mCnt == mAct[4] && !hitVl) ? 1 : 0;
      mSupPk = (pkEv && reloadEn) ? 1 : 0;
      mSupVl = (vlEv && reloadEn) ? 1 : 0;
      if (startNow) begin
        mCnt = mn; mUp = 1;
      end else if (stepNow) begin
        if (pkEv)            begin mCnt = mCnt - 1; mUp = 0; end
        else if (vlEv)       begin mCnt = mCnt + 1; mUp = 1; end
        else if (mUp == 1)   mCnt = mCnt + 1;
        else                 mCnt = mCnt - 1;
      end
      mRun = run ? 1 : 0;
      if (pkEv && reloadEn) begin
        mAct[0] = mBuf[0]; mAct[1] = mBuf[1]; mAct[3] = mBuf[3];
      end
      if (vlEv && reloadEn) begin
        mAct[2] = mBuf[2]; mAct[4] = mBuf[4];
      end
      isDt = wrEn && (wrAddr == 3'd1 || wrAddr == 3'd2);
      dtOk = mUnl == 1 && reloadEn;
      mErr = (isDt && !dtOk) ? 1 : 0;
      if (wrEn && wrAddr <= 3'd4 && (!isDt || dtOk)) begin
        mBuf[wrAddr] = int'(wrData);
        if (!reloadEn) mAct[wrAddr] = int'(wrData);
      end
      if (wrEn) mUnl = (wrAddr == 3'd5 && int'(wrData) == KEY) ? 1 : 0;
    end
    #5;
    if (rstN) begin
      check(int'(cnt) == mCnt, "R3", "counter", int'(cnt), mCnt);
      check(int'(countUp) == mUp, "R3", "direction", int'(countUp), mUp);
      if (hitPk) begin
        supChkPk++;
        check(irqPeak == 1'b0, "R10", "irqPeak after top reload", int'(irqPeak), 0);
      end else begin
        check(int'(irqPeak) == mIrqPk, "R4", "irqPeak", int'(irqPeak), mIrqPk);
      end
      if (hitVl) begin
        supChkVl++;
        check(irqValley == 1'b0, "R11", "irqValley after bottom reload", int'(irqValley), 0);
      end else begin
        check(int'(irqValley) == mIrqVl, "R4", "irqValley", int'(irqValley), mIrqVl);
      end
      check(int'(wrErr) == mErr, "R7", "wrErr", int'(wrErr), mErr);
      if (prevUp == 1 && !countUp) begin lastPeak = prevCnt; nPeaks++; end
      if (prevUp == 0 && countUp && run) begin lastValley = prevCnt; nValleys++; end
      prevCnt = int'(cnt);
      prevUp  = int'(countUp);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic doWrite(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'(a); wrData = W'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitPeaks(input int n);
    int target = nPeaks + n;
    while (nPeaks < target) @(negedge clk);
  endtask

  task automatic waitValleys(input int n);
    int target = nValleys + n;
    while (nValleys < target) @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL R3 watchdog expired: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int held;
    rstN = 1'b0; run = 1'b0; reloadEn = 1'b0;
    wrEn = 1'b0; wrAddr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    check(cnt == '0, "R1", "reset counter", int'(cnt), 0);
    check(countUp == 1'b1, "R1", "reset direction", int'(countUp), 1);
    check({irqPeak, irqValley, wrErr} == 3'b000, "R1", "reset pulses",
          int'({irqPeak, irqValley, wrErr}), 0);
    rstN = 1'b1;

    // immediate compare writes (R6)
    doWrite(3, 10);
    doWrite(4, 5);
    @(negedge clk); run = 1'b1;
    @(negedge clk);
    check(int'(cnt) == DL0 && countUp, "R2", "start value", int'(cnt), DL0);
    waitPeaks(2);
    check(lastPeak == P0 - DH0, "R3", "top turning point", lastPeak, P0 - DH0);
    waitValleys(1);
    check(lastValley == DL0, "R3", "bottom turning point", lastValley, DL0);

    // R6: period takes effect immediately
    doWrite(0, 22);
    waitPeaks(1);
    check(lastPeak == 19, "R6", "peak after immediate period write", lastPeak, 19);

    // R8: dead-time write with reload disabled
    doWrite(5, KEY);
    doWrite(2, 6);
    check(wrErr == 1'b1, "R8", "wrErr, reload off", int'(wrErr), 1);
    waitValleys(2);
    check(lastValley == DL0, "R8", "valley unchanged", lastValley, DL0);

    // R5: buffered period
    @(negedge clk); reloadEn = 1'b1;
    doWrite(0, 24);
    waitPeaks(1);
    check(lastPeak == 19, "R5", "old peak before reload", lastPeak, 19);
    waitPeaks(1);
    check(lastPeak == 21, "R5", "new peak after reload", lastPeak, 21);

    // R7: without key refused, with key accepted
    doWrite(2, 7);
    check(wrErr == 1'b1, "R7", "wrErr without key", int'(wrErr), 1);
    doWrite(5, KEY);
    doWrite(2, 4);
    check(wrErr == 1'b0, "R7", "wrErr with key", int'(wrErr), 0);
    waitValleys(2);
    check(lastValley == 4, "R7", "new valley", lastValley, 4);

    // R9: relock by intervening write or wrong key
    doWrite(5, KEY);
    doWrite(3, 10);
    doWrite(2, 9);
    check(wrErr == 1'b1, "R9", "wrErr after intervening write", int'(wrErr), 1);
    doWrite(5, KEY ^ 1);
    doWrite(2, 9);
    check(wrErr == 1'b1, "R9", "wrErr after wrong key", int'(wrErr), 1);
    doWrite(5, KEY);
    doWrite(7, 0);
    doWrite(1, 9);
    check(wrErr == 1'b1, "R9", "wrErr after unused address", int'(wrErr), 1);
    waitValleys(2);
    check(lastValley == 4, "R9", "valley kept", lastValley, 4);

    // R10: new top bound 20 with peak compare 20
    waitValleys(1);
    doWrite(3, 20);
    doWrite(5, KEY);
    doWrite(1, 4);
    waitPeaks(3);
    check(supChkPk > 0, "R10", "top suppression window reached", supChkPk, 1);

    // R11: new bottom bound 5 with valley compare 5
    waitPeaks(1);
    doWrite(4, 5);
    doWrite(5, KEY);
    doWrite(2, 5);
    waitValleys(3);
    check(supChkVl > 0, "R11", "bottom suppression window reached", supChkVl, 1);

    // R2: stop holds, restart at current minimum
    @(negedge clk); run = 1'b0;
    @(negedge clk); held = int'(cnt);
    repeat (5) @(negedge clk);
    check(int'(cnt) == held, "R2", "hold while stopped", int'(cnt), held);
    run = 1'b1;
    @(negedge clk);
    check(int'(cnt) == 5 && countUp, "R2", "restart value", int'(cnt), 5);
    repeat (40) @(negedge clk);

    summary();
    $finish;
  end

endmodule